// File: doc/BRIEF.md
# Dual-Vector Handshake Interrupt Controller

This block sits between a host bus and a communications microcontroller. It holds a 16-bit control register and an 8-bit status register, and it turns two handshake flags in the status register into two interrupt vectors. The input-ready flag means the device can take a command, and it raises vector A. The output-ready flag means the device holds a result for the host, and it raises vector B. Vector B sits four above vector A, and vector A is the base vector offset by the unit number.

The host enables each vector on its own and asks for a command slot with a request-input bit. It reads the vector during the acknowledge cycle and clears a ready flag once it has moved the data. Clearing a flag withdraws the matching request straight away. After the host takes a slot, input-ready stays low until the device reports, through a completion pulse, that it can take the next command. This stops the next interrupt from following at once. The host reaches both registers with plain, bit-set and bit-clear writes. All pins are plain control and status signals, and the block has no streaming interface.

Top module: `dual_vec_intc`

## Requirements
- R1: After reset, the control register, the status register, `irq_req`, `irq_vec_vld` and both maintenance outputs are zero.
- R2: A host write with `host_sel`=0 targets the control register and one with `host_sel`=1 targets the status register, using the low 8 data bits. The `host_op` value decides the effect: 0 replaces the register, 1 ORs the data in, 2 clears the bits set in the data, and 3 leaves the register unchanged.
- R3: While control bit 7 (request-input) is 1, no command is outstanding and no status write is in progress, status bit 4 (input-ready) is set on the next clock.
- R4: When the host clears input-ready, input-ready stays 0 until `dev_cmd_done` has pulsed. The bit sets again on the second clock after that pulse.
- R5: A `dev_out_post` pulse sets status bit 7 (output-ready) on the next clock. It overrides a host write in the same cycle that clears that bit.
- R6: Request A latches only when input-ready rises while control bit 0 is 1. Request B latches only when output-ready rises while control bit 1 is 1. Turning an enable on while its flag is already high raises nothing. `irq_req` is the OR of the two latched requests.
- R7: A latched request is withdrawn one clock after its ready flag or its enable goes to 0.
- R8: On `irq_ack`, request A is granted ahead of request B. On the next clock, `irq_vec_vld` is high for one cycle with `irq_vec` = VEC_BASE + UNIT*UNIT_STRIDE for A, or that value plus 4 for B.
- R9: An acknowledge clears only the granted request. An acknowledge with nothing pending produces no `irq_vec_vld`.
- R10: Control bits 8 (single-step) and 9 (force-microinstruction) drive `maint_step` and `maint_force` and have no effect on the interrupt logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| host_op | input | 2 | Write kind: 0 replace, 1 set bits, 2 clear bits, 3 none |
| host_wdata | input | 16 | Write data |
| ctrl_rd | output | 16 | Control register contents |
| stat_rd | output | 8 | Status register contents |
| dev_cmd_done | input | 1 | Device has absorbed the previous command |
| dev_out_post | input | 1 | Device posts a result (sets output-ready) |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vec | output | VEC_W | Granted vector |
| irq_vec_vld | output | 1 | Vector valid, one cycle after acknowledge |
| maint_step | output | 1 | Single-step maintenance control |
| maint_force | output | 1 | Force-microinstruction maintenance control |

## Verification
The register path is driven with a table that covers every write kind on both registers, including the unused kind and upper data bits that a status write must discard. This separates replace, set and clear from each other. The handshake is driven through request-input, host clear, device completion and device post, so that a rising flag can be told apart from a flag that was already high. Acknowledges are applied with only A pending, with both pending, with only B pending, and with nothing pending. Together these distinguish the priority order, the A/B vector offset, the single-request clear and the case where no vector is produced. The enable gating and withdrawal cases are driven separately, as is the case where a device post and a host clear land in the same cycle.

// File: rtl/dvic_pkg.sv
package dvic_pkg;
  localparam int CTRL_W = 16;
  localparam int STAT_W = 8;
  localparam int NREQ   = 2;

  localparam int C_EN_A   = 0;
  localparam int C_EN_B   = 1;
  localparam int C_REQ_IN = 7;
  localparam int C_STEP   = 8;
  localparam int C_FORCE  = 9;

  localparam int S_IN_RDY  = 4;
  localparam int S_OUT_RDY = 7;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } host_op_e;
endpackage

// File: rtl/dvic_csr.sv
module dvic_csr
  import dvic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [1:0]        wr_op,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              cmd_done_i,
  input  logic              out_post_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [STAT_W-1:0] stat_q, stat_n, stat_d;
  logic              busy_q, busy_n;
  logic              ctrl_hit, stat_hit;
  host_op_e          op;

  assign op       = host_op_e'(wr_op);
  assign ctrl_hit = wr_en && !wr_sel;
  assign stat_hit = wr_en && wr_sel;
  assign stat_d   = wr_data[STAT_W-1:0];

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctrl_hit) begin
      case (op)
        OP_LOAD:  ctrl_n = wr_data;
        OP_SET:   ctrl_n = ctrl_q | wr_data;
        OP_CLEAR: ctrl_n = ctrl_q & ~wr_data;
        default:  ctrl_n = ctrl_q;
      endcase
    end
  end

  always_comb begin
    stat_n = stat_q;
    if (stat_hit) begin
      case (op)
        OP_LOAD:  stat_n = stat_d;
        OP_SET:   stat_n = stat_q | stat_d;
        OP_CLEAR: stat_n = stat_q & ~stat_d;
        default:  stat_n = stat_q;
      endcase
    end
    // a result from the device is never lost to a racing host clear
    if (out_post_i) stat_n[S_OUT_RDY] = 1'b1;
    // offer a command slot when asked and the previous one was absorbed
    if (!stat_hit && ctrl_q[C_REQ_IN] && !busy_q && !stat_q[S_IN_RDY])
      stat_n[S_IN_RDY] = 1'b1;
  end

  always_comb begin
    busy_n = busy_q;
    if (cmd_done_i) busy_n = 1'b0;
    if (stat_q[S_IN_RDY] && !stat_n[S_IN_RDY]) busy_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      busy_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
      busy_q <= busy_n;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;

  a_r3_slot_offered: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_REQ_IN] && !busy_q && !stat_hit) |=> stat_q[S_IN_RDY]);

  a_r4_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cmd_done_i && !stat_hit && !stat_q[S_IN_RDY]) |=> !stat_q[S_IN_RDY]);

  a_r5_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
    out_post_i |=> stat_q[S_OUT_RDY]);

  a_r2_none_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && op == OP_NONE) |=> $stable(ctrl_q));
endmodule

// File: rtl/dvic_req_latch.sv
module dvic_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_i,
  input  logic en_i,
  input  logic ack_i,
  output logic pend_o
);
  logic rdy_d, pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_d  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      rdy_d <= rdy_i;
      if (!rdy_i || !en_i || ack_i) pend_q <= 1'b0;
      else if (!rdy_d)              pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  a_r6_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(rdy_i) && $past(en_i) && !$past(rdy_d)));

  a_r7_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_i || !en_i) |=> !pend_q);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !pend_q);
endmodule

// File: rtl/dvic_vec_arb.sv
module dvic_vec_arb #(
  parameter int NREQ        = 2,
  parameter int VEC_W       = 9,
  parameter int VEC_BASE    = 256,
  parameter int UNIT        = 2,
  parameter int UNIT_STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_i,
  input  logic [NREQ-1:0]  pend_i,
  output logic [NREQ-1:0]  ack_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_vld_o
);
  localparam int SEL_W = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [VEC_W-1:0] VEC_A = VEC_W'(VEC_BASE + UNIT * UNIT_STRIDE);

  logic [SEL_W-1:0] sel;
  logic [VEC_W-1:0] vec_q, vec_n;
  logic             vld_q, grant;

  // lowest index wins: vector A ahead of vector B
  always_comb begin
    sel = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (pend_i[i]) sel = SEL_W'(i);
  end

  assign grant = iack_i && (|pend_i);
  assign vec_n = VEC_A + (VEC_W'(sel) << 2);

  always_comb begin
    ack_o = '0;
    if (grant) ack_o[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= grant;
      if (grant) vec_q <= vec_n;
    end
  end

  assign vec_o     = vec_q;
  assign vec_vld_o = vld_q;

  a_r8_a_first: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && pend_i[0]) |=> (vec_vld_o && vec_o == VEC_A));

  a_r8_b_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && !pend_i[0] && pend_i[NREQ-1]) |=> (vec_vld_o && vec_o == VEC_A + VEC_W'(4 * (NREQ - 1))));

  a_r9_no_empty_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && pend_i == '0) |=> !vec_vld_o);

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
endmodule

// File: rtl/dual_vec_intc.sv
module dual_vec_intc
  import dvic_pkg::*;
#(
  parameter int VEC_W       = 9,
  parameter int VEC_BASE    = 256,
  parameter int UNIT        = 2,
  parameter int UNIT_STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [1:0]        host_op,
  input  logic [CTRL_W-1:0] host_wdata,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [STAT_W-1:0] stat_rd,
  input  logic              dev_cmd_done,
  input  logic              dev_out_post,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              irq_vec_vld,
  output logic              maint_step,
  output logic              maint_force
);
  logic [CTRL_W-1:0] ctrl;
  logic [STAT_W-1:0] stat;
  logic [NREQ-1:0]   rdy_vec, en_vec, pend_vec, ack_vec;

  dvic_csr u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (host_wr),
    .wr_sel     (host_sel),
    .wr_op      (host_op),
    .wr_data    (host_wdata),
    .cmd_done_i (dev_cmd_done),
    .out_post_i (dev_out_post),
    .ctrl_o     (ctrl),
    .stat_o     (stat)
  );

  assign rdy_vec = {stat[S_OUT_RDY], stat[S_IN_RDY]};
  assign en_vec  = {ctrl[C_EN_B], ctrl[C_EN_A]};

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    dvic_req_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .rdy_i  (rdy_vec[g]),
      .en_i   (en_vec[g]),
      .ack_i  (ack_vec[g]),
      .pend_o (pend_vec[g])
    );
  end

  dvic_vec_arb #(
    .NREQ        (NREQ),
    .VEC_W       (VEC_W),
    .VEC_BASE    (VEC_BASE),
    .UNIT        (UNIT),
    .UNIT_STRIDE (UNIT_STRIDE)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack_i    (irq_ack),
    .pend_i    (pend_vec),
    .ack_o     (ack_vec),
    .vec_o     (irq_vec),
    .vec_vld_o (irq_vec_vld)
  );

  assign irq_req     = |pend_vec;
  assign ctrl_rd     = ctrl;
  assign stat_rd     = stat;
  assign maint_step  = ctrl[C_STEP];
  assign maint_force = ctrl[C_FORCE];

  a_r6_req_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(|(rdy_vec & en_vec)));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (!irq_req && !irq_vec_vld && ctrl_rd == '0 && stat_rd == '0));
endmodule

// File: tb/tb_dual_vec_intc.sv
module tb_dual_vec_intc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [8:0] VA = 9'd272;
  localparam logic [8:0] VB = 9'd276;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_sel = 1'b0;
  logic [1:0]  host_op = 2'd0;
  logic [15:0] host_wdata = '0;
  logic [15:0] ctrl_rd;
  logic [7:0]  stat_rd;
  logic        dev_cmd_done = 1'b0, dev_out_post = 1'b0;
  logic        irq_req, irq_ack = 1'b0;
  logic [8:0]  irq_vec;
  logic        irq_vec_vld, maint_step, maint_force;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_vec_intc dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_op(host_op), .host_wdata(host_wdata), .ctrl_rd(ctrl_rd),
    .stat_rd(stat_rd), .dev_cmd_done(dev_cmd_done), .dev_out_post(dev_out_post),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .irq_vec_vld(irq_vec_vld), .maint_step(maint_step), .maint_force(maint_force)
  );

  typedef struct packed {
    logic        sel;
    logic [1:0]  op;
    logic [15:0] data;
    logic [15:0] exp_ctrl;
    logic [7:0]  exp_stat;
  } row_t;

  localparam row_t TBL [0:10] = '{
    '{1'b0, 2'd0, 16'h0302, 16'h0302, 8'h00},
    '{1'b0, 2'd1, 16'h0040, 16'h0342, 8'h00},
    '{1'b0, 2'd2, 16'h0202, 16'h0140, 8'h00},
    '{1'b0, 2'd3, 16'hFFFF, 16'h0140, 8'h00},
    '{1'b1, 2'd0, 16'h0005, 16'h0140, 8'h05},
    '{1'b1, 2'd1, 16'h0060, 16'h0140, 8'h65},
    '{1'b1, 2'd2, 16'h0044, 16'h0140, 8'h21},
    '{1'b1, 2'd3, 16'h00FF, 16'h0140, 8'h21},
    '{1'b1, 2'd0, 16'hAB0A, 16'h0140, 8'h0A},
    '{1'b0, 2'd0, 16'h0000, 16'h0000, 8'h0A},
    '{1'b1, 2'd2, 16'h00FF, 16'h0000, 8'h00}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic hwrite(logic sel, logic [1:0] op, logic [15:0] d);
    host_wr = 1'b1; host_sel = sel; host_op = op; host_wdata = d;
    step(1);
    host_wr = 1'b0;
  endtask

  task automatic post();
    dev_out_post = 1'b1; step(1); dev_out_post = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ctrl", ctrl_rd, 0);
    check("R1 stat", stat_rd, 0);
    check("R1 irq", {irq_req, irq_vec_vld, maint_step, maint_force}, 0);

    // R2 / R10 register access table
    for (int i = 0; i < 11; i++) begin
      hwrite(TBL[i].sel, TBL[i].op, TBL[i].data);
      check("R2 ctrl", ctrl_rd, TBL[i].exp_ctrl);
      check("R2 stat", stat_rd, TBL[i].exp_stat);
      check("R10 maint", {maint_force, maint_step}, TBL[i].exp_ctrl[9:8]);
      check("R10 irq", irq_req, 0);
    end

    // R3 request-input offers a slot, R6 raises A
    hwrite(1'b0, 2'd1, 16'h0081);
    step(2);
    check("R3 in_rdy", stat_rd[4], 1);
    check("R6 irq A", irq_req, 1);

    // R8 vector A, R9 request cleared
    ack();
    check("R8 vld", irq_vec_vld, 1);
    check("R8 vec A", irq_vec, VA);
    check("R9 cleared", irq_req, 0);
    step(1);
    check("R8 one cycle", irq_vec_vld, 0);
    step(3);
    check("R6 no retrigger", irq_req, 0);

    // R4 slot held until device completion
    hwrite(1'b1, 2'd2, 16'h0010);
    step(4);
    check("R4 held", stat_rd[4], 0);
    check("R4 no irq", irq_req, 0);
    dev_cmd_done = 1'b1; step(1); dev_cmd_done = 1'b0;
    step(1);
    check("R4 reoffered", stat_rd[4], 1);
    step(1);
    check("R4 irq A", irq_req, 1);

    // R5 post, R8 priority with both pending
    hwrite(1'b0, 2'd1, 16'h0002);
    post();
    check("R5 out_rdy", stat_rd[7], 1);
    step(1);
    ack();
    check("R8 A first", irq_vec, VA);
    check("R9 B kept", irq_req, 1);
    ack();
    check("R8 vec B", irq_vec, VB);
    check("R8 vld B", irq_vec_vld, 1);
    check("R9 all done", irq_req, 0);

    // R7 withdraw on ready clear, R9 empty acknowledge
    hwrite(1'b1, 2'd2, 16'h0080);
    post();
    step(1);
    check("R6 irq B", irq_req, 1);
    hwrite(1'b1, 2'd2, 16'h0080);
    step(1);
    check("R7 ready drop", irq_req, 0);
    ack();
    check("R9 no vec", irq_vec_vld, 0);

    // R5 post beats same-cycle host clear
    dev_out_post = 1'b1;
    host_wr = 1'b1; host_sel = 1'b1; host_op = 2'd2; host_wdata = 16'h0080;
    step(1);
    dev_out_post = 1'b0; host_wr = 1'b0;
    check("R5 race", stat_rd[7], 1);
    hwrite(1'b1, 2'd2, 16'h0080);
    step(2);

    // R6 enable gating
    hwrite(1'b0, 2'd2, 16'h0002);
    post();
    step(1);
    check("R6 gated flag", stat_rd[7], 1);
    check("R6 gated irq", irq_req, 0);
    hwrite(1'b0, 2'd1, 16'h0002);
    step(2);
    check("R6 late enable", irq_req, 0);

    // R7 withdraw on enable clear
    hwrite(1'b1, 2'd2, 16'h0080);
    post();
    step(1);
    check("R7 pending", irq_req, 1);
    hwrite(1'b0, 2'd2, 16'h0002);
    step(1);
    check("R7 enable drop", irq_req, 0);

    // R10 maintenance bits
    hwrite(1'b0, 2'd1, 16'h0300);
    check("R10 pins", {maint_force, maint_step}, 2'b11);
    step(2);
    check("R10 no irq", irq_req, 0);
    check("R10 stat", stat_rd, 8'h90);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule